// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This combinational unit prepares the second operand of a 32-bit data-processing datapath. It also produces the carry-out of the shift stage, which the ALU flag logic uses for logical operations. A source word is shifted or rotated by one of four shift types. The shift count comes either from a 5-bit field held in the instruction or from the low byte of a register. A separate immediate-operand mode ignores the source word and instead builds the operand from an 8-bit constant and a 4-bit rotate field.

Each shift type treats a count of zero, and counts of 32 and above, in its own way, and each has its own rule for the carry-out. A zero immediate count turns rotate-right into a one-bit rotate through the carry flag, so the result is 33 bits wide in effect. Because the unit is purely combinational, the operand and carry settle in the same cycle as the inputs. It holds no state and has no clock.

Top module: `shifter_operand_unit`

## Requirements
- R1: `kind_i` encodes the shift type as 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right. For a count n from 1 to 31, the result is the shifted or rotated source. A left shift takes its carry-out from source bit 32-n. The right shifts and the rotate take it from source bit n-1.
- R2: With an instruction-held count (`amt_from_reg_i`=0), a logical left shift by 0 returns the source unchanged, and the carry-out equals `carry_i`.
- R3: With an instruction-held count of 0, a logical right shift acts as a shift by 32: the result is 0 and the carry is bit 31. An arithmetic right shift acts the same way: every result bit is a copy of bit 31, and the carry is bit 31.
- R4: With an instruction-held count of 0, rotate right becomes rotate-through-carry by one. The result is {`carry_i`, source[31:1]} and the carry-out is source bit 0.
- R5: An instruction-held count uses only `amount_i[4:0]`. Bits 7:5 have no effect on the operand or the carry.
- R6: With a register count (`amt_from_reg_i`=1), all 8 bits of `amount_i` are used. A count of 0 passes the source through unchanged with carry-out equal to `carry_i`, for every shift type.
- R7: With a register count, a logical left shift by 32 gives 0 with carry equal to bit 0. A logical right shift by 32 gives 0 with carry equal to bit 31. Either shift by more than 32 gives 0 with carry 0.
- R8: With a register count of 32 or more, an arithmetic right shift fills the result with bit 31, and the carry equals bit 31.
- R9: With a register count, rotate right uses the count modulo 32. A nonzero count that is a multiple of 32 returns the source unchanged, with carry equal to bit 31.
- R10: With `imm_mode_i`=1, the operand is `imm_field_i[7:0]`, zero-extended and rotated right by twice `imm_field_i[11:8]`. The carry-out equals `carry_i`. This mode takes precedence over `src_i`, `kind_i`, `amount_i` and `amt_from_reg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source word to shift or rotate |
| kind_i | input | 2 | Shift type selector |
| amount_i | input | 8 | Shift count (low 5 bits for instruction-held counts) |
| amt_from_reg_i | input | 1 | 1 selects the 8-bit register count, 0 the 5-bit instruction count |
| imm_mode_i | input | 1 | 1 selects the rotated-constant operand |
| imm_field_i | input | 12 | Rotate field [11:8] and constant [7:0] |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifter operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Two functions can be selected together: the rotated-constant mode and the count decoding of the shift path. The test that provokes this asserts `imm_mode_i` while the shift inputs select a pass-through, a rotate-through-carry or an over-range zero. The operand and carry are then judged against the rotated constant alone. A second overlap arises inside rotate-through-carry, where the incoming carry feeds result bit 31 and source bit 0 feeds the carry-out in the same evaluation. The tests set `carry_i` and source bit 0 to opposite values so that a crossed wire shows on both outputs.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      OS_SHIFT = 2'd0,
      OS_PASS  = 2'd1,
      OS_ZERO  = 2'd2,
      OS_RRX   = 2'd3
   } out_sel_e;

endpackage

// File: rtl/sop_count_decode.sv
`timescale 1ns/1ps
// Turns the raw count and type into a funnel offset, a direction and a
// special-case selector.
module sop_count_decode
   import sop_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   parameter int CNT_W     = $clog2(DATA_W) + 1
) (
   input  shift_kind_e          kind_i,
   input  logic [REG_AMT_W-1:0] amount_i,
   input  logic                 amt_from_reg_i,
   output out_sel_e             sel_o,
   output logic                 left_o,
   output logic [CNT_W-1:0]     cnt_o
);
   localparam int                   LOG_W  = $clog2(DATA_W);
   localparam logic [CNT_W-1:0]     FULL   = CNT_W'(DATA_W);
   localparam logic [REG_AMT_W-1:0] FULL_R = REG_AMT_W'(DATA_W);

   logic [LOG_W-1:0]     imm_n;
   logic [REG_AMT_W-1:0] reg_n;
   logic [LOG_W-1:0]     rot_n;

   assign imm_n = amount_i[LOG_W-1:0];
   assign reg_n = amount_i;
   assign rot_n = amount_i[LOG_W-1:0];

   always_comb begin
      sel_o  = OS_SHIFT;
      left_o = 1'b0;
      cnt_o  = '0;
      if (!amt_from_reg_i) begin
         unique case (kind_i)
            SK_LSL: begin
               if (imm_n == '0) begin
                  sel_o = OS_PASS;
               end else begin
                  left_o = 1'b1;
                  cnt_o  = FULL - CNT_W'(imm_n);
               end
            end
            SK_LSR, SK_ASR: begin
               cnt_o = (imm_n == '0) ? FULL : CNT_W'(imm_n);
            end
            SK_ROR: begin
               if (imm_n == '0) sel_o = OS_RRX;
               else             cnt_o = CNT_W'(imm_n);
            end
         endcase
      end else if (reg_n == '0) begin
         sel_o = OS_PASS;
      end else begin
         unique case (kind_i)
            SK_LSL: begin
               if (reg_n < FULL_R) begin
                  left_o = 1'b1;
                  cnt_o  = FULL - CNT_W'(reg_n);
               end else if (reg_n == FULL_R) begin
                  left_o = 1'b1;
               end else begin
                  sel_o = OS_ZERO;
               end
            end
            SK_LSR: begin
               if (reg_n <= FULL_R) cnt_o = CNT_W'(reg_n);
               else                 sel_o = OS_ZERO;
            end
            SK_ASR: begin
               cnt_o = (reg_n >= FULL_R) ? FULL : CNT_W'(reg_n);
            end
            SK_ROR: begin
               cnt_o = (rot_n == '0) ? FULL : CNT_W'(rot_n);
            end
         endcase
      end
   end
endmodule

// File: rtl/sop_funnel_core.sv
`timescale 1ns/1ps
// Double-width funnel: a right shift of a guarded 2W-bit word by 0..W.
// win_o[W:1] is the result, win_o[0] the bit shifted out last to the
// right, win_o[W+1] the bit just above the window (left-shift carry).
module sop_funnel_core
   import sop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = $clog2(DATA_W) + 1,
   parameter bit LOG_BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] src_i,
   input  shift_kind_e       kind_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W+1:0] win_o
);
   localparam int EXT_W = 2 * DATA_W + 2;
   localparam int WIN_W = DATA_W + 2;

   logic [2*DATA_W-1:0] word;
   logic [EXT_W-1:0]    ext;

   always_comb begin
      unique case (kind_i)
         SK_LSL: word = {src_i, {DATA_W{1'b0}}};
         SK_LSR: word = {{DATA_W{1'b0}}, src_i};
         SK_ASR: word = {{DATA_W{src_i[DATA_W-1]}}, src_i};
         SK_ROR: word = {src_i, src_i};
      endcase
   end

   assign ext = {1'b0, word, 1'b0};

   generate
      if (LOG_BARREL) begin : g_log
         logic [EXT_W-1:0] st [CNT_W+1];
         assign st[0] = ext;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign st[k+1] = cnt_i[k] ? (st[k] >> (1 << k)) : st[k];
         end
         assign win_o = st[CNT_W][WIN_W-1:0];
      end else begin : g_flat
         assign win_o = ext[cnt_i +: WIN_W];
      end
   endgenerate
endmodule

// File: rtl/sop_imm_rotator.sv
`timescale 1ns/1ps
// Rotated-constant operand: constant rotated right by twice the field.
module sop_imm_rotator #(
   parameter int DATA_W  = 32,
   parameter int CONST_W = 8,
   parameter int ROT_W   = 4
) (
   input  logic [CONST_W+ROT_W-1:0] field_i,
   output logic [DATA_W-1:0]        value_o
);
   logic [DATA_W-1:0]   base;
   logic [2*DATA_W-1:0] dbl;
   logic [ROT_W:0]      rot_amt;

   assign base    = DATA_W'(field_i[CONST_W-1:0]);
   assign dbl     = {base, base};
   assign rot_amt = {field_i[CONST_W+ROT_W-1:CONST_W], 1'b0};
   assign value_o = dbl[rot_amt +: DATA_W];
endmodule

// File: rtl/shifter_operand_unit.sv
`timescale 1ns/1ps
module shifter_operand_unit
   import sop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int REG_AMT_W  = 8,
   parameter int CONST_W    = 8,
   parameter int ROT_W      = 4,
   parameter bit LOG_BARREL = 1'b1
) (
   input  logic [DATA_W-1:0]        src_i,
   input  logic [1:0]               kind_i,
   input  logic [REG_AMT_W-1:0]     amount_i,
   input  logic                     amt_from_reg_i,
   input  logic                     imm_mode_i,
   input  logic [CONST_W+ROT_W-1:0] imm_field_i,
   input  logic                     carry_i,
   output logic [DATA_W-1:0]        operand_o,
   output logic                     carry_o
);
   localparam int CNT_W = $clog2(DATA_W) + 1;

   generate
      if ((1 << $clog2(DATA_W)) != DATA_W || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 8");
      end
      if (REG_AMT_W < CNT_W) begin : g_bad_amt
         $error("REG_AMT_W must express counts above DATA_W");
      end
      if (2 * ((1 << ROT_W) - 1) >= DATA_W || CONST_W > DATA_W) begin : g_bad_imm
         $error("constant rotate range exceeds DATA_W");
      end
   endgenerate

   shift_kind_e         kind;
   out_sel_e            sel;
   logic                left;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W+1:0]   win;
   logic [DATA_W-1:0]   imm_val;

   assign kind = shift_kind_e'(kind_i);

   sop_count_decode #(
      .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .CNT_W(CNT_W)
   ) u_decode (
      .kind_i(kind), .amount_i(amount_i), .amt_from_reg_i(amt_from_reg_i),
      .sel_o(sel), .left_o(left), .cnt_o(cnt)
   );

   sop_funnel_core #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .LOG_BARREL(LOG_BARREL)
   ) u_core (
      .src_i(src_i), .kind_i(kind), .cnt_i(cnt), .win_o(win)
   );

   sop_imm_rotator #(
      .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
   ) u_imm (
      .field_i(imm_field_i), .value_o(imm_val)
   );

   always_comb begin
      if (imm_mode_i) begin
         operand_o = imm_val;
         carry_o   = carry_i;
      end else begin
         unique case (sel)
            OS_PASS: begin
               operand_o = src_i;
               carry_o   = carry_i;
            end
            OS_ZERO: begin
               operand_o = '0;
               carry_o   = 1'b0;
            end
            OS_RRX: begin
               operand_o = {carry_i, src_i[DATA_W-1:1]};
               carry_o   = src_i[0];
            end
            OS_SHIFT: begin
               operand_o = win[DATA_W:1];
               carry_o   = left ? win[DATA_W+1] : win[0];
            end
         endcase
      end
   end
endmodule

// File: rtl/shifter_operand_chk.sv
`timescale 1ns/1ps
module shifter_operand_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   parameter int CONST_W   = 8,
   parameter int ROT_W     = 4
) (
   input logic [DATA_W-1:0]        src_i,
   input logic [1:0]               kind_i,
   input logic [REG_AMT_W-1:0]     amount_i,
   input logic                     amt_from_reg_i,
   input logic                     imm_mode_i,
   input logic [CONST_W+ROT_W-1:0] imm_field_i,
   input logic                     carry_i,
   input logic [DATA_W-1:0]        operand_o,
   input logic                     carry_o
);
   localparam int LOG_W = $clog2(DATA_W);

   always_comb begin
      if (imm_mode_i) begin
         p_imm_carry_r10: assert (carry_o == carry_i)
            else $error("imm-mode carry differs from carry_i");
         if (imm_field_i[CONST_W+ROT_W-1:CONST_W] == '0) begin
            p_imm_norot_r10: assert (operand_o == DATA_W'(imm_field_i[CONST_W-1:0]))
               else $error("unrotated constant altered");
         end
      end else begin
         if (amt_from_reg_i && amount_i == '0) begin
            p_reg_zero_pass_r6: assert (operand_o == src_i && carry_o == carry_i)
               else $error("zero register count not a pass-through");
         end
         if (!amt_from_reg_i && kind_i == 2'd3 && amount_i[LOG_W-1:0] == '0) begin
            p_rrx_r4: assert (operand_o == {carry_i, src_i[DATA_W-1:1]} && carry_o == src_i[0])
               else $error("rotate-through-carry wrong");
         end
         if (amt_from_reg_i && kind_i[1] == 1'b0 && amount_i > REG_AMT_W'(DATA_W)) begin
            p_over_zero_r7: assert (operand_o == '0 && carry_o == 1'b0)
               else $error("over-range logical shift not zero");
         end
         if (kind_i == 2'd2) begin
            p_asr_sign_r8: assert (operand_o[DATA_W-1] == src_i[DATA_W-1])
               else $error("arithmetic shift lost sign");
         end
         if (amt_from_reg_i && kind_i == 2'd3 && amount_i != '0
             && amount_i[LOG_W-1:0] == '0) begin
            p_ror_wrap_r9: assert (operand_o == src_i && carry_o == src_i[DATA_W-1])
               else $error("rotate by multiple of width wrong");
         end
      end
   end
endmodule

bind shifter_operand_unit shifter_operand_chk #(
   .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
) u_chk (
   .src_i(src_i), .kind_i(kind_i), .amount_i(amount_i),
   .amt_from_reg_i(amt_from_reg_i), .imm_mode_i(imm_mode_i),
   .imm_field_i(imm_field_i), .carry_i(carry_i),
   .operand_o(operand_o), .carry_o(carry_o)
);

// File: tb/shifter_operand_unit_tb.sv
`timescale 1ns/1ps
module shifter_operand_unit_tb;
   logic        clk = 1'b0;
   logic [31:0] src;
   logic [1:0]  kind;
   logic [7:0]  amt;
   logic        use_reg;
   logic        imm;
   logic [11:0] field;
   logic        cin;
   logic [31:0] operand;
   logic        cout;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #4 clk = ~clk;

   shifter_operand_unit u_dut (
      .src_i(src), .kind_i(kind), .amount_i(amt), .amt_from_reg_i(use_reg),
      .imm_mode_i(imm), .imm_field_i(field), .carry_i(cin),
      .operand_o(operand), .carry_o(cout)
   );

   // Expected {carry, operand} written from the requirement list.
   function automatic logic [32:0] model(logic [31:0] s, logic [1:0] k, logic [7:0] a,
                                         logic rg, logic im, logic [11:0] f, logic ci);
      logic [31:0] r;
      logic        c;
      int          n;
      int          m;
      int          ra;
      logic [31:0] cc;
      r = '0; c = 1'b0;
      if (im) begin
         ra = 2 * int'(f[11:8]);
         cc = {24'b0, f[7:0]};
         r  = (ra == 0) ? cc : ((cc >> ra) | (cc << (32 - ra)));
         c  = ci;
      end else begin
         n = rg ? int'(a) : int'(a[4:0]);
         if (n == 0 && (rg || k == 2'd0)) begin
            r = s; c = ci;
         end else if (n == 0) begin
            case (k)
               2'd1:    begin r = '0;          c = s[31]; end
               2'd2:    begin r = {32{s[31]}}; c = s[31]; end
               default: begin r = {ci, s[31:1]}; c = s[0]; end
            endcase
         end else begin
            case (k)
               2'd0: begin
                  if (n < 32)       begin r = s << n; c = s[32-n]; end
                  else if (n == 32) begin r = '0; c = s[0]; end
                  else              begin r = '0; c = 1'b0; end
               end
               2'd1: begin
                  if (n < 32)       begin r = s >> n; c = s[n-1]; end
                  else if (n == 32) begin r = '0; c = s[31]; end
                  else              begin r = '0; c = 1'b0; end
               end
               2'd2: begin
                  if (n < 32) begin r = $signed(s) >>> n; c = s[n-1]; end
                  else        begin r = {32{s[31]}}; c = s[31]; end
               end
               default: begin
                  m = n % 32;
                  if (m == 0) begin r = s; c = s[31]; end
                  else begin r = (s >> m) | (s << (32 - m)); c = s[m-1]; end
               end
            endcase
         end
      end
      return {c, r};
   endfunction

   task automatic drive(logic [31:0] s, logic [1:0] k, logic [7:0] a,
                        logic rg, logic im, logic [11:0] f, logic ci);
      @(negedge clk);
      src = s; kind = k; amt = a; use_reg = rg; imm = im; field = f; cin = ci;
      #1;
   endtask

   task automatic expect_vals(string tag, logic [31:0] exp_op, logic exp_c);
      checks++;
      if (operand !== exp_op || cout !== exp_c) begin
         errors++;
         $display("FAIL %s: got operand=%h carry=%b expected operand=%h carry=%b",
                  tag, operand, cout, exp_op, exp_c);
      end
   endtask

   task automatic run(string tag, logic [31:0] s, logic [1:0] k, logic [7:0] a,
                      logic rg, logic im, logic [11:0] f, logic ci);
      logic [32:0] e;
      drive(s, k, a, rg, im, f, ci);
      e = model(s, k, a, rg, im, f, ci);
      expect_vals(tag, e[31:0], e[32]);
   endtask

   task automatic t_reset;
      drive('0, 2'd0, 8'd0, 1'b0, 1'b0, 12'd0, 1'b0);
      expect_vals("R2 idle zero inputs", 32'h0, 1'b0);
   endtask

   task automatic t_normal_counts;
      logic [31:0] pats [5] = '{32'h8000_0001, 32'hA5A5_5A5A, 32'h7FFF_FFFE,
                                32'hF0F0_0F0F, 32'h0001_8000};
      int ns [5] = '{1, 5, 16, 30, 31};
      for (int p = 0; p < 5; p++)
         for (int k = 0; k < 4; k++)
            for (int i = 0; i < 5; i++)
               for (int rg = 0; rg < 2; rg++)
                  run("R1 normal count", pats[p], 2'(k), 8'(ns[i]), 1'(rg),
                      1'b0, 12'h000, 1'(p % 2));
      drive(32'h8000_0001, 2'd0, 8'd4, 1'b0, 1'b0, 12'h0, 1'b1);
      expect_vals("R1 lsl 4", 32'h0000_0010, 1'b0);
      drive(32'h0000_0018, 2'd1, 8'd4, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R1 lsr 4", 32'h0000_0001, 1'b1);
      drive(32'h0000_0003, 2'd3, 8'd1, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R1 ror 1", 32'h8000_0001, 1'b1);
   endtask

   task automatic t_imm_zero;
      drive(32'h1234_5678, 2'd0, 8'd0, 1'b0, 1'b0, 12'h0, 1'b1);
      expect_vals("R2 lsl #0", 32'h1234_5678, 1'b1);
      drive(32'h8000_0000, 2'd1, 8'd0, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R3 lsr #0 as 32", 32'h0, 1'b1);
      drive(32'h8000_0010, 2'd2, 8'd0, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R3 asr #0 negative", 32'hFFFF_FFFF, 1'b1);
      drive(32'h7000_0000, 2'd2, 8'd0, 1'b0, 1'b0, 12'h0, 1'b1);
      expect_vals("R3 asr #0 positive", 32'h0, 1'b0);
      drive(32'h0000_0003, 2'd3, 8'd0, 1'b0, 1'b0, 12'h0, 1'b1);
      expect_vals("R4 rrx carry in", 32'h8000_0001, 1'b1);
      drive(32'h0000_0002, 2'd3, 8'd0, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R4 rrx no carry", 32'h0000_0001, 1'b0);
   endtask

   task automatic t_imm_high_ignored;
      for (int k = 0; k < 4; k++) begin
         run("R5 bits 7:5 ignored", 32'hC3A5_0F81, 2'(k), 8'hE3, 1'b0, 1'b0, 12'h0, 1'b1);
         run("R5 count 32 reads as 0", 32'hC3A5_0F81, 2'(k), 8'h20, 1'b0, 1'b0, 12'h0, 1'b0);
      end
      drive(32'h0000_00F0, 2'd1, 8'hE4, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R5 lsr E4 acts as 4", 32'h0000_000F, 1'b0);
   endtask

   task automatic t_reg_zero;
      for (int k = 0; k < 4; k++) begin
         drive(32'hDEAD_BEEF, 2'(k), 8'd0, 1'b1, 1'b0, 12'h0, 1'b1);
         expect_vals("R6 reg zero pass c1", 32'hDEAD_BEEF, 1'b1);
         drive(32'h8000_0001, 2'(k), 8'd0, 1'b1, 1'b0, 12'h0, 1'b0);
         expect_vals("R6 reg zero pass c0", 32'h8000_0001, 1'b0);
      end
   endtask

   task automatic t_reg_large;
      int amts [7] = '{31, 32, 33, 63, 64, 96, 255};
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 7; i++) begin
            run("R7 R8 R9 large reg count", 32'h8000_0001, 2'(k), 8'(amts[i]),
                1'b1, 1'b0, 12'h0, 1'b0);
            run("R7 R8 R9 large reg count", 32'h4000_0002, 2'(k), 8'(amts[i]),
                1'b1, 1'b0, 12'h0, 1'b1);
         end
      drive(32'h8000_0001, 2'd0, 8'd32, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R7 lsl 32", 32'h0, 1'b1);
      drive(32'h8000_0001, 2'd1, 8'd32, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R7 lsr 32", 32'h0, 1'b1);
      drive(32'hFFFF_FFFF, 2'd0, 8'd33, 1'b1, 1'b0, 12'h0, 1'b1);
      expect_vals("R7 lsl 33", 32'h0, 1'b0);
      drive(32'hFFFF_FFFF, 2'd1, 8'd200, 1'b1, 1'b0, 12'h0, 1'b1);
      expect_vals("R7 lsr 200", 32'h0, 1'b0);
      drive(32'h8000_0001, 2'd2, 8'd255, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R8 asr 255", 32'hFFFF_FFFF, 1'b1);
      drive(32'h7FFF_FFFF, 2'd2, 8'd40, 1'b1, 1'b0, 12'h0, 1'b1);
      expect_vals("R8 asr 40 positive", 32'h0, 1'b0);
      drive(32'h8000_0001, 2'd3, 8'd64, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R9 ror 64", 32'h8000_0001, 1'b1);
      drive(32'h8000_0001, 2'd3, 8'd33, 1'b1, 1'b0, 12'h0, 1'b0);
      expect_vals("R9 ror 33", 32'hC000_0000, 1'b1);
   endtask

   task automatic t_imm_operand;
      drive(32'hFFFF_FFFF, 2'd1, 8'd7, 1'b1, 1'b1, 12'h0FF, 1'b1);
      expect_vals("R10 rot 0", 32'h0000_00FF, 1'b1);
      drive(32'h1234_5678, 2'd2, 8'd0, 1'b0, 1'b1, 12'h1FF, 1'b0);
      expect_vals("R10 rot 1", 32'hC000_003F, 1'b0);
      drive(32'h0, 2'd3, 8'd1, 1'b0, 1'b1, 12'hF81, 1'b1);
      expect_vals("R10 rot 15", 32'h0000_0204, 1'b1);
      for (int r = 0; r < 16; r++)
         run("R10 rotate sweep", 32'hA5A5_A5A5, 2'd0, 8'd3, 1'b0, 1'b1,
             {4'(r), 8'hC3}, 1'(r % 2));
   endtask

   task automatic t_overlap;
      drive(32'h1357_9BDF, 2'd0, 8'd0, 1'b1, 1'b1, 12'h4AB, 1'b0);
      expect_vals("R10 over reg pass", 32'hAB00_0000, 1'b0);
      drive(32'h0000_0001, 2'd3, 8'd0, 1'b0, 1'b1, 12'h011, 1'b0);
      expect_vals("R10 over rrx", 32'h0000_0011, 1'b0);
      drive(32'hFFFF_FFFF, 2'd0, 8'd99, 1'b1, 1'b1, 12'h27F, 1'b1);
      expect_vals("R10 over zero", 32'hF000_0007, 1'b1);
      drive(32'hFFFF_FFFE, 2'd3, 8'd0, 1'b0, 1'b0, 12'h0, 1'b1);
      expect_vals("R4 rrx crossed carry", 32'hFFFF_FFFF, 1'b0);
      drive(32'h0000_0001, 2'd3, 8'd0, 1'b0, 1'b0, 12'h0, 1'b0);
      expect_vals("R4 rrx crossed carry 2", 32'h0000_0000, 1'b1);
   endtask

   initial begin
      src = '0; kind = '0; amt = '0; use_reg = 1'b0; imm = 1'b0; field = '0; cin = 1'b0;
      t_reset();
      t_normal_counts();
      t_imm_zero();
      t_imm_high_ignored();
      t_reg_zero();
      t_reg_large();
      t_imm_operand();
      t_overlap();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule